// File: doc/BRIEF.md
# Sensor Register Bank with SPI Slave Access

This block gives a host processor SPI access to the register bank of a small three-axis sensor. Each transaction opens with a command byte that selects read or write, single or multiple bytes, and a 6-bit starting register. The data bytes that follow move between the serial lines and the register bank. An internal pointer steps forward by one after every data byte, so a single transaction can cover a run of neighbouring registers.

The three axis samples come in as live 16-bit words from the sensing pipeline. Each one is mapped as a little-endian byte pair. When a read burst begins on an axis low byte, all six axis bytes are frozen into a shadow copy. The rest of that burst then returns consistent low and high halves, even if the live samples change in mid-burst. The FIFO configuration byte is held in the bank and also driven out to the neighbouring FIFO logic. The FIFO status byte is supplied by that logic and can only be read.

The serial pins are asynchronous to the system clock. They are resynchronised and their edges are detected in the system clock domain. The bus runs in clock-idles-high mode: MOSI is captured on the rising SCK edge and MISO changes after the falling edge.

Top module: `spi_sensor_regs`

## Requirements
- R1: A transaction starts only on a high-to-low change of chip select. A rise of chip select ends the transaction at once, and a partly shifted byte is discarded without any write. While no transaction is active, MISO is driven 0.
- R2: The first byte after select is the command, shifted most-significant bit first. Bit 7 = 1 requests a read and 0 a write, bit 6 = 1 enables multiple data bytes, and bits 5:0 hold the starting register address.
- R3: In a write, each data byte, taken MSB first from MOSI, is stored at the current pointer if that address is a storage register (0x00 to 0x31, or 0x38). Register 0x38 drives the `fifo_ctrl` output: bits 7:6 mode, bit 5 trigger select, bits 4:0 sample count.
- R4: In a read, the byte at the current pointer appears on MISO MSB first. Each bit changes after a falling SCK edge and is valid at the following rising edge. MISO is 0 during the command byte and during every byte of a write.
- R5: The pointer increases by one after every complete data byte. It wraps from 0x3F to 0x00.
- R6: With the multiple-byte flag at 0, only the first data byte is transferred. Later write bytes in that transaction are dropped, and later read bytes return 0xFF.
- R7: Addresses 0x3A to 0x3F have no backing registers. Writes to them are dropped and reads from them return 0x00.
- R8: The axis samples are read-only. X is at 0x32 (low) and 0x33 (high), Y at 0x34/0x35, and Z at 0x36/0x37. Writes to 0x32 to 0x37 are dropped.
- R9: The first axis low-byte read in a transaction copies all six live axis bytes into a shadow. Every later axis read in that transaction returns the shadow. An axis read that comes before any low-byte read returns the live value.
- R10: Register 0x39 is read-only. It returns the `fifo_status` input with bit 7 (triggered) and bits 5:0 (entry count) passed through, and bit 6 forced to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock, idles high, asynchronous |
| spi_cs_n | input | 1 | Chip select, active low, asynchronous |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| sample_x | input | 16 | Live X-axis sample |
| sample_y | input | 16 | Live Y-axis sample |
| sample_z | input | 16 | Live Z-axis sample |
| fifo_status | input | 8 | FIFO status from the neighbouring FIFO logic |
| fifo_ctrl | output | 8 | FIFO configuration byte held at register 0x38 |

## Verification
The assertions assume that each SCK level and each chip-select level lasts for several system clocks, so that every serial edge survives the synchroniser as a separate event. They also assume that MOSI is stable around each rising SCK edge and that chip select changes only while SCK is high. The stimulus drives every serial half period for eight system clocks and changes MOSI only right after a falling edge. It moves chip select only while SCK is idle high, and changes the live samples only between whole bytes.

// File: rtl/spi_sensor_pkg.sv
package spi_sensor_pkg;

    localparam int BYTE_W      = 8;
    localparam int ADDR_W      = 6;
    localparam int NUM_ADDR    = 1 << ADDR_W;
    localparam int AXIS_COUNT  = 3;
    localparam int SAMPLE_BYTES = 2;
    localparam int SAMPLE_W    = AXIS_COUNT > 0 ? SAMPLE_BYTES * BYTE_W : 0;
    localparam int AXIS_BYTES  = AXIS_COUNT * SAMPLE_BYTES;
    localparam int AXIS_IDX_W  = $clog2(AXIS_BYTES);

    localparam logic [ADDR_W-1:0] STORE_LAST    = 6'h31;
    localparam logic [ADDR_W-1:0] AXIS_BASE     = 6'h32;
    localparam logic [ADDR_W-1:0] AXIS_LAST     = AXIS_BASE + ADDR_W'(AXIS_BYTES - 1);
    localparam logic [ADDR_W-1:0] FIFO_CFG_ADR  = 6'h38;
    localparam logic [ADDR_W-1:0] FIFO_STAT_ADR = 6'h39;
    localparam logic [ADDR_W-1:0] LAST_BACKED   = FIFO_STAT_ADR;
    localparam logic [BYTE_W-1:0] STAT_MASK     = 8'hBF;
    localparam logic [BYTE_W-1:0] FILL_BYTE     = 8'hFF;

    typedef struct packed {
        logic              rd;
        logic              burst;
        logic [ADDR_W-1:0] addr;
    } cmd_t;

    typedef enum logic {
        LINK_IDLE,
        LINK_ACTIVE
    } link_t;

    function automatic cmd_t decode_cmd(input logic [BYTE_W-1:0] b);
        cmd_t c;
        c.rd    = b[7];
        c.burst = b[6];
        c.addr  = b[ADDR_W-1:0];
        return c;
    endfunction

    function automatic logic is_store(input logic [ADDR_W-1:0] a);
        return (a <= STORE_LAST) || (a == FIFO_CFG_ADR);
    endfunction

    function automatic logic is_axis(input logic [ADDR_W-1:0] a);
        return (a >= AXIS_BASE) && (a <= AXIS_LAST);
    endfunction

    function automatic logic is_axis_low(input logic [ADDR_W-1:0] a);
        logic [ADDR_W-1:0] off;
        off = a - AXIS_BASE;
        return is_axis(a) && (off[0] == 1'b0);
    endfunction

endpackage

// File: rtl/spi_sensor_sync.sv
module spi_sensor_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= RST_VAL;
        end else begin
            chain[0] <= d;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_sensor_framer.sv
module spi_sensor_framer
    import spi_sensor_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sck_s,
    input  logic              cs_s,
    input  logic              mosi_s,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              spi_miso,
    output logic              active,
    output logic              txn_start,
    output logic              rd_take,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              byte_done,
    output logic [ADDR_W-1:0] ptr,
    output cmd_t              cmd
);
    localparam int CNT_W = $clog2(BYTE_W);

    link_t             state;
    logic              sck_prev, cs_prev;
    logic [CNT_W-1:0]  bit_cnt;
    logic              have_cmd, first_done;
    logic [BYTE_W-1:0] rx_q, tx_q, rx_next;
    logic              sck_rise, sck_fall, cs_fall, cs_rise;
    logic              last_bit, data_en, shift_evt, load_evt;

    assign sck_rise  = sck_s & ~sck_prev;
    assign sck_fall  = ~sck_s & sck_prev;
    assign cs_fall   = cs_prev & ~cs_s;
    assign cs_rise   = ~cs_prev & cs_s;
    assign active    = (state == LINK_ACTIVE);
    assign last_bit  = (bit_cnt == CNT_W'(BYTE_W - 1));
    assign rx_next   = {rx_q[BYTE_W-2:0], mosi_s};
    assign data_en   = cmd.burst | ~first_done;
    assign shift_evt = active & sck_rise & ~cs_rise;
    assign load_evt  = active & sck_fall & ~cs_rise & (bit_cnt == '0) & have_cmd;

    assign txn_start = cs_fall;
    assign byte_done = shift_evt & last_bit & have_cmd;
    assign wr_en     = byte_done & ~cmd.rd & data_en;
    assign wr_addr   = ptr;
    assign wr_data   = rx_next;
    assign rd_take   = load_evt & cmd.rd & data_en;
    assign rd_addr   = ptr;
    assign spi_miso  = active & tx_q[BYTE_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= LINK_IDLE;
            sck_prev   <= 1'b1;
            cs_prev    <= 1'b1;
            bit_cnt    <= '0;
            have_cmd   <= 1'b0;
            first_done <= 1'b0;
            rx_q       <= '0;
            tx_q       <= '0;
            ptr        <= '0;
            cmd        <= '0;
        end else begin
            sck_prev <= sck_s;
            cs_prev  <= cs_s;
            if (cs_rise) begin
                state <= LINK_IDLE;
                tx_q  <= '0;
            end else if (cs_fall) begin
                state      <= LINK_ACTIVE;
                bit_cnt    <= '0;
                have_cmd   <= 1'b0;
                first_done <= 1'b0;
                rx_q       <= '0;
                tx_q       <= '0;
            end else if (active) begin
                if (sck_rise) begin
                    rx_q    <= rx_next;
                    bit_cnt <= bit_cnt + 1'b1;
                    if (last_bit) begin
                        if (!have_cmd) begin
                            cmd      <= decode_cmd(rx_next);
                            ptr      <= rx_next[ADDR_W-1:0];
                            have_cmd <= 1'b1;
                        end else begin
                            ptr        <= ptr + 1'b1;
                            first_done <= 1'b1;
                        end
                    end
                end else if (sck_fall) begin
                    if (load_evt) begin
                        if (cmd.rd) tx_q <= data_en ? rd_data : FILL_BYTE;
                        else        tx_q <= '0;
                    end else begin
                        tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
                    end
                end
            end
        end
    end
endmodule

// File: rtl/spi_sensor_bank.sv
module spi_sensor_bank
    import spi_sensor_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                txn_start,
    input  logic                rd_take,
    input  logic [ADDR_W-1:0]   rd_addr,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [BYTE_W-1:0]   wr_data,
    input  logic [SAMPLE_W-1:0] sample_x,
    input  logic [SAMPLE_W-1:0] sample_y,
    input  logic [SAMPLE_W-1:0] sample_z,
    input  logic [BYTE_W-1:0]   fifo_status,
    output logic [BYTE_W-1:0]   rd_data,
    output logic [BYTE_W-1:0]   fifo_ctrl
);
    logic [SAMPLE_W-1:0]   samp  [AXIS_COUNT];
    logic [BYTE_W-1:0]     live  [AXIS_BYTES];
    logic [BYTE_W-1:0]     shadow[AXIS_BYTES];
    logic [BYTE_W-1:0]     store [NUM_ADDR];
    logic                  snap_valid;
    logic [ADDR_W-1:0]     rd_off;
    logic [AXIS_IDX_W-1:0] rd_idx;

    assign samp[0] = sample_x;
    assign samp[1] = sample_y;
    assign samp[2] = sample_z;

    for (genvar ax = 0; ax < AXIS_COUNT; ax++) begin : g_axis
        for (genvar by = 0; by < SAMPLE_BYTES; by++) begin : g_byte
            assign live[ax*SAMPLE_BYTES + by] = samp[ax][by*BYTE_W +: BYTE_W];
        end
    end

    for (genvar a = 0; a < NUM_ADDR; a++) begin : g_reg
        if (is_store(ADDR_W'(a))) begin : g_rw
            always_ff @(posedge clk) begin
                if (rst)                                 store[a] <= '0;
                else if (wr_en && wr_addr == ADDR_W'(a)) store[a] <= wr_data;
            end
        end else begin : g_none
            assign store[a] = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            snap_valid <= 1'b0;
            for (int i = 0; i < AXIS_BYTES; i++) shadow[i] <= '0;
        end else if (txn_start) begin
            snap_valid <= 1'b0;
        end else if (rd_take && is_axis_low(rd_addr) && !snap_valid) begin
            snap_valid <= 1'b1;
            for (int i = 0; i < AXIS_BYTES; i++) shadow[i] <= live[i];
        end
    end

    assign rd_off = rd_addr - AXIS_BASE;
    assign rd_idx = rd_off[AXIS_IDX_W-1:0];

    always_comb begin
        if (rd_addr > LAST_BACKED)          rd_data = '0;
        else if (is_axis(rd_addr))          rd_data = snap_valid ? shadow[rd_idx] : live[rd_idx];
        else if (rd_addr == FIFO_STAT_ADR)  rd_data = fifo_status & STAT_MASK;
        else                                rd_data = store[rd_addr];
    end

    assign fifo_ctrl = store[FIFO_CFG_ADR];
endmodule

// File: rtl/spi_sensor_regs.sv
module spi_sensor_regs
    import spi_sensor_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        spi_sck,
    input  logic        spi_cs_n,
    input  logic        spi_mosi,
    output logic        spi_miso,
    input  logic [15:0] sample_x,
    input  logic [15:0] sample_y,
    input  logic [15:0] sample_z,
    input  logic [7:0]  fifo_status,
    output logic [7:0]  fifo_ctrl
);
    logic              sck_s, cs_s, mosi_s;
    logic [BYTE_W-1:0] rd_data, wr_data;
    logic [ADDR_W-1:0] rd_addr, wr_addr, ptr;
    logic              active, txn_start, rd_take, wr_en, byte_done;
    cmd_t              cmd;

    spi_sensor_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b110)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({spi_sck, spi_cs_n, spi_mosi}),
        .q   ({sck_s, cs_s, mosi_s})
    );

    spi_sensor_framer u_framer (
        .clk       (clk),
        .rst       (rst),
        .sck_s     (sck_s),
        .cs_s      (cs_s),
        .mosi_s    (mosi_s),
        .rd_data   (rd_data),
        .spi_miso  (spi_miso),
        .active    (active),
        .txn_start (txn_start),
        .rd_take   (rd_take),
        .rd_addr   (rd_addr),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .byte_done (byte_done),
        .ptr       (ptr),
        .cmd       (cmd)
    );

    spi_sensor_bank u_bank (
        .clk         (clk),
        .rst         (rst),
        .txn_start   (txn_start),
        .rd_take     (rd_take),
        .rd_addr     (rd_addr),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .sample_x    (sample_x),
        .sample_y    (sample_y),
        .sample_z    (sample_z),
        .fifo_status (fifo_status),
        .rd_data     (rd_data),
        .fifo_ctrl   (fifo_ctrl)
    );
endmodule

// File: rtl/spi_sensor_regs_chk.sv
module spi_sensor_regs_chk (
    input logic       clk,
    input logic       rst,
    input logic       cs_sync,
    input logic       active,
    input logic       spi_miso,
    input logic       byte_done,
    input logic [5:0] ptr,
    input logic       wr_en,
    input logic [5:0] wr_addr,
    input logic       cmd_rd,
    input logic [7:0] fifo_ctrl
);
    // R1: no drive on MISO outside a transaction
    a_r1_idle_miso_low: assert property (@(posedge clk) disable iff (rst)
        !active |-> !spi_miso);

    // R1: a rise of chip select ends the transaction
    a_r1_cs_rise_ends: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_sync) |=> !active);

    // R5: pointer steps by one after each data byte
    a_r5_ptr_advance: assert property (@(posedge clk) disable iff (rst)
        byte_done |=> ptr == $past(ptr) + 6'd1);

    // R3: stores happen only in write transactions
    a_r3_store_only_on_write: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (active && !cmd_rd));

    // R7: a write to an unbacked address leaves the FIFO config alone
    a_r7_unbacked_write_dropped: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr > 6'h39) |=> $stable(fifo_ctrl));

    // R8: a write to an axis address leaves the FIFO config alone
    a_r8_axis_write_dropped: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr >= 6'h32 && wr_addr <= 6'h37) |=> $stable(fifo_ctrl));
endmodule

bind spi_sensor_regs spi_sensor_regs_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cs_sync   (cs_s),
    .active    (active),
    .spi_miso  (spi_miso),
    .byte_done (byte_done),
    .ptr       (ptr),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .cmd_rd    (cmd.rd),
    .fifo_ctrl (fifo_ctrl)
);

// File: tb/spi_sensor_regs_tb.sv
`timescale 1ns/1ps
module spi_sensor_regs_tb;
    localparam int HALF = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        spi_sck = 1'b1, spi_cs_n = 1'b1, spi_mosi = 1'b0;
    logic        spi_miso;
    logic [15:0] sx = 16'h1234, sy = 16'h5678, sz = 16'h9ABC;
    logic [7:0]  fstat = 8'h00;
    logic [7:0]  fifo_ctrl;

    int checks = 0, fails = 0;
    bit done = 0;

    logic [7:0] mdl [0:63];
    logic [7:0] wbuf [0:7];
    logic [7:0] rbuf [0:7];
    logic [7:0] tb_shadow [0:5];
    bit         tb_snap;

    always #10 clk = ~clk;

    spi_sensor_regs u_dut (
        .clk(clk), .rst(rst), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .sample_x(sx),
        .sample_y(sy), .sample_z(sz), .fifo_status(fstat), .fifo_ctrl(fifo_ctrl)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic bit tb_store(input logic [5:0] a);
        return (a <= 6'h31) || (a == 6'h38);
    endfunction

    function automatic logic [7:0] tb_live(input int i);
        case (i)
            0: return sx[7:0];  1: return sx[15:8];
            2: return sy[7:0];  3: return sy[15:8];
            4: return sz[7:0];  default: return sz[15:8];
        endcase
    endfunction

    function automatic logic [7:0] model_read(input logic [5:0] a);
        int i;
        if (a > 6'h39) return 8'h00;
        if (a >= 6'h32 && a <= 6'h37) begin
            i = int'(a) - 'h32;
            if (!tb_snap && (i % 2 == 0)) begin
                tb_snap = 1;
                for (int k = 0; k < 6; k++) tb_shadow[k] = tb_live(k);
            end
            return tb_snap ? tb_shadow[i] : tb_live(i);
        end
        if (a == 6'h39) return fstat & 8'hBF;
        return mdl[a];
    endfunction

    task automatic spi_byte(input logic [7:0] mo, output logic [7:0] mi, input int nbits);
        mi = 8'h00;
        for (int b = 7; b > 7 - nbits; b--) begin
            spi_sck = 1'b0; spi_mosi = mo[b];
            repeat (HALF) @(negedge clk);
            mi[b] = spi_miso;
            spi_sck = 1'b1;
            repeat (HALF) @(negedge clk);
        end
    endtask

    task automatic cs_open();
        spi_cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic cs_close();
        spi_cs_n = 1'b1;
        repeat (3 * HALF) @(negedge clk);
    endtask

    // one full transaction with expected values from the model; swap_at >= 0
    // changes the live samples after that data byte
    task automatic run_txn(input bit rd, input bit mb, input logic [5:0] addr,
                           input int n, input int swap_at);
        logic [7:0] mi, e;
        logic [5:0] a;
        bit         en;
        tb_snap = 0;
        cs_open();
        spi_byte({rd, mb, addr}, mi, 8);
        chk("R4 command byte miso", mi, 8'h00);
        for (int k = 0; k < n; k++) begin
            a  = addr + 6'(k);
            en = mb || (k == 0);
            if (rd) e = en ? model_read(a) : 8'hFF;
            else    e = 8'h00;
            spi_byte(wbuf[k], mi, 8);
            rbuf[k] = mi;
            if (rd) chk(en ? "R4 R5 read byte" : "R6 fill byte", mi, e);
            else    chk("R4 write miso", mi, 8'h00);
            if (!rd && en && tb_store(a)) mdl[a] = wbuf[k];
            if (k == swap_at) begin
                sx = ~sx; sy = sy + 16'h0101; sz = {sz[7:0], sz[15:8]} ^ 16'h00F0;
            end
        end
        cs_close();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] mi;
        for (int i = 0; i < 64; i++) mdl[i] = 8'h00;
        void'($urandom(32'h5EED_0101));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // reset state
        chk("R1 reset miso", spi_miso, 1'b0);
        chk("R3 reset fifo_ctrl", fifo_ctrl, 8'h00);

        // R2 R3 R5: burst write then burst read
        for (int k = 0; k < 4; k++) wbuf[k] = 8'h11 * (k + 1);
        run_txn(0, 1, 6'h00, 4, -1);
        run_txn(1, 1, 6'h00, 4, -1);
        chk("R2 R3 readback reg 0x03", rbuf[3], 8'h44);

        // R6: single-byte write drops extras, single-byte read fills 0xFF
        wbuf[0] = 8'hC3; wbuf[1] = 8'h3C; wbuf[2] = 8'h5A;
        run_txn(0, 0, 6'h10, 3, -1);
        run_txn(1, 1, 6'h10, 3, -1);
        chk("R6 extra write dropped", rbuf[1], 8'h00);
        run_txn(1, 0, 6'h10, 3, -1);
        chk("R6 fill", rbuf[2], 8'hFF);

        // R3: FIFO config register drives port
        wbuf[0] = 8'hA5;
        run_txn(0, 0, 6'h38, 1, -1);
        chk("R3 fifo_ctrl port", fifo_ctrl, 8'hA5);

        // R7 R5: unbacked writes dropped, reads zero, pointer wraps
        for (int k = 0; k < 8; k++) wbuf[k] = 8'hEE;
        run_txn(0, 1, 6'h3A, 6, -1);
        run_txn(1, 1, 6'h3A, 8, -1);
        chk("R7 unbacked read", rbuf[2], 8'h00);
        chk("R5 wrap to 0x00", rbuf[6], 8'h11);

        // R8 R9: axis burst with samples changed mid-burst
        wbuf[0] = 8'h77;
        run_txn(0, 1, 6'h32, 1, -1);
        for (int k = 0; k < 8; k++) wbuf[k] = 8'h00;
        run_txn(1, 1, 6'h32, 6, 0);
        chk("R9 coherent X high", {rbuf[1], rbuf[0]}, 32'h1234);
        chk("R9 coherent Z", {rbuf[5], rbuf[4]}, 32'h9ABC);
        run_txn(1, 0, 6'h33, 1, -1);
        chk("R8 R9 live high byte", rbuf[0], {24'h0, sx[15:8]});

        // R10: status register masking
        fstat = 8'hFF;
        run_txn(1, 0, 6'h39, 1, -1);
        chk("R10 status bit6 cleared", rbuf[0], 8'hBF);
        wbuf[0] = 8'h00;
        run_txn(0, 0, 6'h39, 1, -1);
        fstat = 8'h85;
        run_txn(1, 0, 6'h39, 1, -1);

        // R1: abort mid byte, nothing stored
        cs_open();
        spi_byte({2'b00, 6'h20}, mi, 8);
        spi_byte(8'hF0, mi, 4);
        cs_close();
        run_txn(1, 0, 6'h20, 1, -1);
        chk("R1 aborted byte not stored", rbuf[0], 8'h00);

        // random transactions
        for (int t = 0; t < 40; t++) begin
            bit rd, mb;
            logic [5:0] ad;
            int n;
            rd = 1'($urandom % 2);
            mb = 1'($urandom % 4 != 0);
            ad = 6'($urandom % 64);
            n  = 1 + int'($urandom % 4);
            for (int k = 0; k < 8; k++) wbuf[k] = 8'($urandom);
            fstat = 8'($urandom);
            if ($urandom % 5 == 0) begin
                sx = 16'($urandom); sy = 16'($urandom); sz = 16'($urandom);
            end
            run_txn(rd, mb, ad, n, -1);
            chk("R3 fifo_ctrl tracks model", fifo_ctrl, mdl[6'h38]);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule